// File: doc/BRIEF.md
# Frame-counting HDLC byte buffer

This block is a single-channel byte buffer for traffic bound to or coming from a serial HDLC engine. It is a ring buffer in on-chip memory with a write position and a read position. Alongside them it keeps a second, narrower pair of counters. One counts complete frames that have been stored and the other counts complete frames that have been read out. A reader can therefore see that a whole frame is waiting without looking at how many bytes the buffer holds. The buffer holds plain payload bytes only. Zero-bit insertion, zero-bit removal and CRC handling are done on the line side, outside this block.

The writer presents one byte per cycle and marks the last byte of each frame. A marker bit is stored with every byte, so the reader gets an end-of-frame indication with the last byte. The output frame counter advances in the same cycle that the last byte is taken. The buffer comes out of reset disabled. It starts working only after its mode field is written with a nonzero value.

If a byte does not fit, either because the byte ring is full or because the frame ring is full, the byte is refused and a sticky overflow flag is set. The frame that was being written is dropped as a whole: the write position falls back to where that frame began, and the rest of that frame is ignored up to and including its end marker.

Top module: `hdlc_frame_fifo`

## Requirements
- R1: During reset and in the first cycle after it, `empty`=1, `frame_avail`=0, `overflow`=0 and `rd_valid`=0, and the buffer is disabled.
- R2: The buffer is enabled by a cycle with `cfg_we`=1 and `cfg_mode` nonzero, and disabled by a cycle with `cfg_we`=1 and `cfg_mode`=0. While it is disabled, writes and reads are ignored: `empty`, `frame_avail` and `rd_valid` do not change.
- R3: Bytes come out in the order they were written. An accepted read gives `rd_valid`=1 in the next cycle, with that byte on `rd_data`. `rd_eof`=1 goes with the byte that was written with `wr_eof`=1.
- R4: `empty` is 1 exactly when the write byte position equals the read byte position. It updates in the cycle after the accepted write or read, and this includes bytes of a frame that is still incomplete.
- R5: `frame_avail` is 1 exactly when the stored-frame counter differs from the read-frame counter. It rises in the cycle after a byte with `wr_eof`=1 is accepted. It falls in the cycle after the last byte of the last stored frame is read.
- R6: A read request while `frame_avail`=0 is ignored, and this includes the empty case: `rd_valid` stays 0 and no position moves.
- R7: With 2^ADDR_W-1 bytes stored (write position plus one equals read position), a write is refused. `overflow` becomes 1 in the next cycle and stays 1 until a cycle with `cfg_we`=1. If a refusal and a `cfg_we` fall in the same cycle, the flag is set.
- R8: With 2^FCNT_W-1 complete frames stored, any write is refused and `overflow` is set.
- R9: On a refusal, every byte already accepted for that frame is discarded. Later bytes are ignored up to and including the next byte with `wr_eof`=1, and the frame after that is accepted normally.
- R10: A read and a write in the same cycle are both carried out.
- R11: The frame counters wrap modulo 2^FCNT_W. Passing more frames than that through the buffer keeps `frame_avail` and the data correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode write strobe; also clears `overflow` |
| cfg_mode | input | MODE_W | Mode value; nonzero enables the buffer |
| wr_valid | input | 1 | Write byte strobe |
| wr_data | input | DATA_W | Write byte |
| wr_eof | input | 1 | Marks the written byte as the last of its frame |
| rd_req | input | 1 | Read request |
| rd_valid | output | 1 | Read byte valid, one cycle after the accepted request |
| rd_data | output | DATA_W | Read byte |
| rd_eof | output | 1 | Read byte is the last of its frame |
| empty | output | 1 | Byte positions are equal |
| frame_avail | output | 1 | At least one complete frame is stored |
| overflow | output | 1 | Sticky flag: a write was refused |

## Verification
The collision that matters is a write and a read landing in the same cycle. The fullness checks use the read position from before the cycle, so a byte written while a read frees room is still refused. A refusal can also meet a rollback while the reader is draining an older frame. The bench provokes both with directed same-cycle read/write steps and with long random runs whose bias alternates between filling and draining, so the buffer often sits at the byte and frame limits. A bench model applies the same ordering rule and predicts every flag and byte, and the outputs are compared with it each cycle.

// File: rtl/hfifo_pkg.sv
package hfifo_pkg;

  // Write-side state: accepting bytes, or discarding the rest of a refused frame
  typedef enum logic {
    WR_PASS    = 1'b0,
    WR_DISCARD = 1'b1
  } wr_state_e;

endpackage

// File: rtl/hfifo_ram.sv
// Simple dual-port buffer: registered read port (block RAM style) plus a
// register vector of end-of-frame marks that is read without latency.
module hfifo_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              weof,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              reof,
  output logic              eof_at_raddr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WORD_W = DATA_W + 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  eof_vec;
  logic [WORD_W-1:0] rword_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {weof, wdata};
  end

  always_ff @(posedge clk) begin
    if (re) rword_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (we) eof_vec[waddr] <= weof;
  end

  assign rdata        = rword_q[DATA_W-1:0];
  assign reof         = rword_q[DATA_W];
  assign eof_at_raddr = eof_vec[raddr];
endmodule

// File: rtl/hfifo_wr_ctrl.sv
// Write side: byte position, frame-start position, stored-frame counter,
// refusal, rollback and the sticky overflow flag.
module hfifo_wr_ctrl
  import hfifo_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int FCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr_ovf,
  input  logic              wr_valid,
  input  logic              wr_eof,
  input  logic [ADDR_W-1:0] rout,
  input  logic [FCNT_W-1:0] fout,
  output logic              wr_accept,
  output logic [ADDR_W-1:0] win,
  output logic [ADDR_W-1:0] win_next,
  output logic [FCNT_W-1:0] fin_next,
  output logic              overflow
);
  localparam logic [ADDR_W-1:0] AONE = ADDR_W'(1);
  localparam logic [FCNT_W-1:0] FONE = FCNT_W'(1);

  logic [ADDR_W-1:0] win_q, start_q, start_n;
  logic [FCNT_W-1:0] fin_q;
  wr_state_e         st_q, st_n;
  logic              ovf_q;
  logic              byte_full, frm_full, attempt, reject;

  always_comb begin
    byte_full = (win_q + AONE) == rout;
    frm_full  = (fin_q + FONE) == fout;
    attempt   = en && wr_valid && (st_q == WR_PASS);
    wr_accept = attempt && !byte_full && !frm_full;
    reject    = attempt && (byte_full || frm_full);

    if (wr_accept)   win_next = win_q + AONE;
    else if (reject) win_next = start_q;
    else             win_next = win_q;

    fin_next = (wr_accept && wr_eof) ? fin_q + FONE : fin_q;
    start_n  = (wr_accept && wr_eof) ? win_q + AONE : start_q;

    st_n = st_q;
    if (reject && !wr_eof)
      st_n = WR_DISCARD;
    else if (st_q == WR_DISCARD && en && wr_valid && wr_eof)
      st_n = WR_PASS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= '0;
      start_q <= '0;
      fin_q   <= '0;
      st_q    <= WR_PASS;
      ovf_q   <= 1'b0;
    end else begin
      win_q   <= win_next;
      start_q <= start_n;
      fin_q   <= fin_next;
      st_q    <= st_n;
      ovf_q   <= (ovf_q && !clr_ovf) || reject;
    end
  end

  assign win      = win_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/hfifo_rd_ctrl.sv
// Read side: byte position, read-frame counter and read-valid register.
module hfifo_rd_ctrl #(
  parameter int ADDR_W = 6,
  parameter int FCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rd_req,
  input  logic              frame_ready,
  input  logic              eof_now,
  output logic              rd_accept,
  output logic [ADDR_W-1:0] rout,
  output logic [ADDR_W-1:0] rout_next,
  output logic [FCNT_W-1:0] fout,
  output logic [FCNT_W-1:0] fout_next,
  output logic              rd_valid
);
  logic [ADDR_W-1:0] rout_q;
  logic [FCNT_W-1:0] fout_q;
  logic              rv_q;

  always_comb begin
    rd_accept = en && rd_req && frame_ready;
    rout_next = rd_accept ? rout_q + ADDR_W'(1) : rout_q;
    fout_next = (rd_accept && eof_now) ? fout_q + FCNT_W'(1) : fout_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rout_q <= '0;
      fout_q <= '0;
      rv_q   <= 1'b0;
    end else begin
      rout_q <= rout_next;
      fout_q <= fout_next;
      rv_q   <= rd_accept;
    end
  end

  assign rout     = rout_q;
  assign fout     = fout_q;
  assign rd_valid = rv_q;
endmodule

// File: rtl/hdlc_frame_fifo.sv
module hdlc_frame_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int FCNT_W = 4,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eof,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eof,
  output logic              empty,
  output logic              frame_avail,
  output logic              overflow
);
  logic              en_q;
  logic              empty_q, favail_q;
  logic              wr_accept, rd_accept, eof_now;
  logic [ADDR_W-1:0] win, win_next, rout, rout_next;
  logic [FCNT_W-1:0] fin_next, fout, fout_next;

  // Enable: follows the last mode write, off after reset
  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (cfg_we) en_q <= |cfg_mode;
  end

  hfifo_wr_ctrl #(.ADDR_W(ADDR_W), .FCNT_W(FCNT_W)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .en        (en_q),
    .clr_ovf   (cfg_we),
    .wr_valid  (wr_valid),
    .wr_eof    (wr_eof),
    .rout      (rout),
    .fout      (fout),
    .wr_accept (wr_accept),
    .win       (win),
    .win_next  (win_next),
    .fin_next  (fin_next),
    .overflow  (overflow)
  );

  hfifo_rd_ctrl #(.ADDR_W(ADDR_W), .FCNT_W(FCNT_W)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .en          (en_q),
    .rd_req      (rd_req),
    .frame_ready (favail_q),
    .eof_now     (eof_now),
    .rd_accept   (rd_accept),
    .rout        (rout),
    .rout_next   (rout_next),
    .fout        (fout),
    .fout_next   (fout_next),
    .rd_valid    (rd_valid)
  );

  hfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk          (clk),
    .we           (wr_accept),
    .waddr        (win),
    .wdata        (wr_data),
    .weof         (wr_eof),
    .re           (rd_accept),
    .raddr        (rout),
    .rdata        (rd_data),
    .reof         (rd_eof),
    .eof_at_raddr (eof_now)
  );

  // Status flags registered from next-state positions and counters
  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q  <= 1'b1;
      favail_q <= 1'b0;
    end else begin
      empty_q  <= (win_next == rout_next);
      favail_q <= (fin_next != fout_next);
    end
  end

  assign empty       = empty_q;
  assign frame_avail = favail_q;
endmodule

// File: rtl/hdlc_frame_fifo_chk.sv
module hdlc_frame_fifo_chk (
  input logic clk,
  input logic rst,
  input logic cfg_we,
  input logic wr_valid,
  input logic wr_eof,
  input logic rd_req,
  input logic rd_valid,
  input logic empty,
  input logic frame_avail,
  input logic overflow
);
  logic rst_d = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      // R1
      reset_state_chk: assert (empty && !frame_avail && !overflow && !rd_valid)
        else $error("reset state wrong");
    end
  end

  // R6
  rd_without_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !frame_avail) |=> !rd_valid);

  // R4
  frame_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
    frame_avail |-> !empty);

  // R4
  empty_falls_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(empty) |-> $past(wr_valid));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !cfg_we) |=> overflow);

  // R3
  rd_valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));

  // R5
  frame_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_avail) |-> $past(wr_valid && wr_eof));
endmodule

bind hdlc_frame_fifo hdlc_frame_fifo_chk u_chk (.*);

// File: tb/sim_hdlc_frame_fifo.sv
`timescale 1ns/1ps
module sim_hdlc_frame_fifo;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int FCNT_W = 4;
  localparam int MODE_W = 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int FMAX   = 1 << FCNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [MODE_W-1:0] cfg_mode = '0;
  logic wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_eof = 1'b0;
  logic rd_req = 1'b0;
  logic rd_valid, rd_eof, empty, frame_avail, overflow;
  logic [DATA_W-1:0] rd_data;

  always #2.5 clk = ~clk;

  hdlc_frame_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FCNT_W(FCNT_W), .MODE_W(MODE_W)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_eof(wr_eof), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_eof(rd_eof),
    .empty(empty), .frame_avail(frame_avail), .overflow(overflow)
  );

  int checks = 0;
  int fails  = 0;

  // Bench model state
  logic [DATA_W:0] q[$];
  int   nfrm = 0;
  int   part = 0;
  bit   drop_m = 0;
  bit   en_m = 0;
  bit   ovf_m = 0;
  bit   exp_rv = 0;
  logic [DATA_W:0] exp_word = '0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_full();
    return (q.size() == DEPTH - 1) || (nfrm == FMAX - 1);
  endfunction

  // One cycle: drive at negedge, update model, compare at next negedge
  task automatic step(input string tag, input bit wv, input logic [DATA_W-1:0] wd,
                      input bit we, input bit rr, input bit cw = 0,
                      input logic [MODE_W-1:0] cm = '0);
    bit rd_acc, wr_try, full;
    wr_valid = wv; wr_data = wd; wr_eof = we; rd_req = rr;
    cfg_we = cw; cfg_mode = cm;
    full   = is_full();
    rd_acc = en_m && rr && (nfrm > 0);
    wr_try = en_m && wv && !drop_m;
    exp_rv = rd_acc;
    if (rd_acc) begin
      exp_word = q.pop_front();
      if (exp_word[DATA_W]) nfrm--;
    end
    ovf_m = (ovf_m && !cw) || (wr_try && full);
    if (wr_try && full) begin
      for (int i = 0; i < part; i++) void'(q.pop_back());
      part = 0;
      drop_m = !we;
    end else if (wr_try) begin
      q.push_back({we, wd});
      if (we) begin nfrm++; part = 0; end
      else part++;
    end else if (en_m && wv && drop_m && we) begin
      drop_m = 0;
    end
    if (cw) en_m = (cm != 0);
    @(negedge clk);
    chk(tag, "R6 rd_valid", rd_valid, exp_rv);
    if (exp_rv) chk(tag, "R3 rd_word", {rd_eof, rd_data}, exp_word);
    chk(tag, "R4 empty", empty, q.size() == 0);
    chk(tag, "R5 frame_avail", frame_avail, nfrm > 0);
    chk(tag, "R7 overflow", overflow, ovf_m);
    wr_valid = 0; rd_req = 0; cfg_we = 0;
  endtask

  task automatic wframe(input string tag, input int n, input int base);
    for (int i = 0; i < n; i++)
      step(tag, 1, DATA_W'(base + i), i == n - 1, 0);
  endtask

  task automatic drain(input string tag);
    while (nfrm > 0) step(tag, 0, '0, 0, 1);
    step(tag, 0, '0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "empty", empty, 1);
    chk("R1", "frame_avail", frame_avail, 0);
    chk("R1", "overflow", overflow, 0);
    chk("R1", "rd_valid", rd_valid, 0);

    // R2: disabled after reset, writes and reads ignored
    wframe("R2", 3, 8'h10);
    step("R2", 0, '0, 0, 1);
    step("R2", 0, '0, 0, 0, 1, 2'd0);
    wframe("R2", 2, 8'h20);
    step("R2", 0, '0, 0, 0, 1, 2'd2);

    // R3/R4/R5: partial frame clears empty, eof raises frame_avail
    wframe("R4", 3, 8'h30);
    wframe("R5", 2, 8'h40);
    drain("R3");

    // R6: read while empty, then read during a partial frame
    step("R6", 0, '0, 0, 1);
    step("R6", 1, 8'h55, 0, 0);
    step("R6", 0, '0, 0, 1);
    step("R6", 1, 8'h56, 1, 0);
    drain("R6");

    // R10: simultaneous read and write
    wframe("R10", 2, 8'h60);
    for (int i = 0; i < 6; i++) step("R10", 1, DATA_W'(8'h70 + i), i % 2 == 1, 1);
    drain("R10");

    // R7: byte ring full with 7 frames of 9 bytes, then refusal
    for (int f = 0; f < 7; f++) wframe("R7", 9, f * 16);
    step("R7", 1, 8'hAA, 1, 0);
    step("R7", 0, '0, 0, 0);
    step("R7", 0, '0, 0, 0, 1, 2'd1);
    drain("R7");

    // R8: frame ring full
    for (int f = 0; f < FMAX - 1; f++) wframe("R8", 1, f);
    step("R8", 1, 8'hBB, 1, 0);
    step("R8", 0, '0, 0, 0, 1, 2'd1);
    drain("R8");

    // R9: oversize frame rolled back, tail ignored, next frame kept
    wframe("R9", 2, 8'hC0);
    for (int i = 0; i < DEPTH + 4; i++) step("R9", 1, DATA_W'(i), 0, 0);
    step("R9", 1, 8'hEE, 1, 0);
    wframe("R9", 3, 8'hD0);
    step("R9", 0, '0, 0, 0, 1, 2'd3);
    drain("R9");

    // R11: many frames through to wrap the frame counters
    for (int f = 0; f < 3 * FMAX; f++) begin
      wframe("R11", 1 + f % 3, f);
      if (f % 2 == 1) drain("R11");
    end
    drain("R11");

    // Random mix, bias alternating between fill and drain
    for (int c = 0; c < 6000; c++) begin
      bit fillp;
      fillp = ((c / 400) % 2) == 0;
      step("R10", ($urandom % 10) < (fillp ? 7 : 3), DATA_W'($urandom),
           ($urandom % 5) == 0, ($urandom % 10) < (fillp ? 3 : 7),
           ($urandom % 150) == 0, 2'd1);
    end
    drain("R3");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule